// File: doc/BRIEF.md
# Second-Aligned Timing Pulse Generator

This block drives one timing output pin from a time-of-day count made of a seconds value and a nanoseconds value. That count runs freely, advances every clock and comes from outside the block. When the pin is programmed for the clock action with second alignment on, the pin gives one pulse per second. The pulse opens a programmable number of nanoseconds after the seconds value steps, and it stays open for a programmable number of nanoseconds. When the clock action is chosen without second alignment, the pin toggles freely between a low interval and a high interval. These intervals are measured in elapsed time-of-day nanoseconds, and they never re-align to the second.

Software programs the pin through a small word-wide register port with combinational reads. That port holds a pin configuration word, a pulse-width register and a pulse-delay register. It also gives read-only views of the live seconds and nanoseconds. A write lands in a pending copy. The pending copy becomes the working copy only when the seconds value next changes, so a pulse that is already running is never cut short. Every port is a plain control or status pin. No port carries a data stream, so the block has no valid/ready handshake and nothing can apply back-pressure.

Top module: `pps_pulse_gen`

## Requirements
- R1: While reset is held and after it is released, `pulse_out` is 0. The configuration word reads 0, the pulse-width register reads 1000 and the pulse-delay register reads 0.
- R2: The register offsets are as follows. 0x00 is the configuration word. 0x04 is bits 63:32 of the seconds value (zero-extended), 0x08 is bits 31:0 of the seconds value, and 0x0C is the nanoseconds value. 0x14 is the pulse width and 0x18 is the pulse delay. The width and delay registers keep NS_W bits, and their upper bits read 0. Writes to the read-only offsets are ignored, and any unmapped offset reads 0.
- R3: The configuration word has these fields. Bit 0 is a domain select, which is stored and read back. Bit 1 is polarity. Bit 2 is second alignment. Bits 5:3 are the action, where 0 means idle and 1 means the clock action; every other code behaves as idle. Bits 31:6 read 0.
- R4: With the clock action and alignment on, `pulse_out` is active one cycle after a sampled nanoseconds value that lies in [delay, delay+width). This gives exactly one rising edge per seconds step when delay < NS_PER_SEC and 0 < width < NS_PER_SEC.
- R5: When delay+width exceeds NS_PER_SEC, the pulse ends at the seconds step.
- R6: Setting the polarity bit inverts `pulse_out` in every mode.
- R7: With the idle action, or with any code other than the clock action, `pulse_out` holds the inactive level, which is the polarity bit.
- R8: All three registers take effect at the first cycle in which the seconds value differs from the previous cycle. A write made in that same cycle waits for the following seconds step.
- R9: With the clock action and alignment off, a phase counter advances by the elapsed nanoseconds each cycle, modulo delay+width. The output is active while phase ≥ delay, and the phase is kept across seconds steps. If delay+width is 0, the output is inactive. The per-cycle advance must stay below delay+width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tod_sec | input | SEC_W | Time-of-day seconds |
| tod_ns | input | NS_W | Time-of-day nanoseconds, below NS_PER_SEC |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pulse_out | output | 1 | Timing output pin |

## Verification
The bench builds the block with NS_PER_SEC set to 2000 and the time of day advancing 8 ns per clock, so one second is 250 cycles. This brings many seconds steps into a short run. It also makes the default 1000 ns pulse half a second long, and it lets a delay of 1500 with a width of 1000 reach the truncation at the seconds step. The seconds value starts above 2^32, which exercises both halves of the seconds readback. Free-running mode uses a 64 ns period, so the phase wraps every 8 cycles and crosses seconds steps.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int ACT_W      = 3;
  localparam logic [ACT_W-1:0] ACT_IDLE  = 3'd0;
  localparam logic [ACT_W-1:0] ACT_CLOCK = 3'd1;

  localparam int OFF_CFG    = 'h00;
  localparam int OFF_SEC_HI = 'h04;
  localparam int OFF_SEC_LO = 'h08;
  localparam int OFF_NSEC   = 'h0C;
  localparam int OFF_WIDTH  = 'h14;
  localparam int OFF_DELAY  = 'h18;

  // Packed so that dom is bit 0, pol bit 1, sync bit 2, act bits 5:3.
  typedef struct packed {
    logic [ACT_W-1:0] act;
    logic             sync;
    logic             pol;
    logic             dom;
  } pin_cfg_t;

  localparam int CFG_W = $bits(pin_cfg_t);

  function automatic logic [31:0] cfg_pack(pin_cfg_t c);
    return 32'(c);
  endfunction

  function automatic pin_cfg_t cfg_unpack(logic [31:0] w);
    return pin_cfg_t'(w[CFG_W-1:0]);
  endfunction
endpackage

// File: rtl/pps_tod_edge.sv
module pps_tod_edge #(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 30,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SEC_W-1:0] tod_sec,
  input  logic [NS_W-1:0]  tod_ns,
  output logic            sec_tick,
  output logic [NS_W:0]   ns_delta
);
  localparam logic [NS_W:0] NPS = (NS_W+1)'(NS_PER_SEC);

  logic             prev_valid;
  logic [SEC_W-1:0] prev_sec;
  logic [NS_W-1:0]  prev_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_valid <= 1'b0;
      prev_sec   <= '0;
      prev_ns    <= '0;
    end else begin
      prev_valid <= 1'b1;
      prev_sec   <= tod_sec;
      prev_ns    <= tod_ns;
    end
  end

  assign sec_tick = prev_valid && (tod_sec != prev_sec);

  always_comb begin
    if (!prev_valid)
      ns_delta = '0;
    else if (sec_tick)
      ns_delta = {1'b0, tod_ns} + NPS - {1'b0, prev_ns};
    else
      ns_delta = {1'b0, tod_ns} - {1'b0, prev_ns};
  end

  // R9: elapsed time per cycle never exceeds one second for a legal ToD
  p_delta_in_second_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prev_valid |-> (ns_delta <= NPS));
endmodule

// File: rtl/pps_cfg_regs.sv
module pps_cfg_regs
  import pps_pkg::*;
#(
  parameter int SEC_W     = 48,
  parameter int NS_W      = 30,
  parameter int ADDR_W    = 8,
  parameter int DEF_WIDTH = 1000,
  parameter int DEF_DELAY = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [SEC_W-1:0] tod_sec,
  input  logic [NS_W-1:0]  tod_ns,
  input  logic             load,
  output logic             eff_pol,
  output logic             eff_sync,
  output logic [ACT_W-1:0] eff_act,
  output logic [NS_W-1:0]  eff_width,
  output logic [NS_W-1:0]  eff_delay
);
  pin_cfg_t        pend_cfg, act_cfg, eff_cfg;
  logic [NS_W-1:0] pend_width, pend_delay, act_width, act_delay;
  logic [31:0]     sec_hi, sec_lo;
  logic            unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cfg   <= '0;
      pend_width <= NS_W'(DEF_WIDTH);
      pend_delay <= NS_W'(DEF_DELAY);
    end else if (reg_wr) begin
      if (int'(reg_addr) == OFF_CFG)   pend_cfg   <= cfg_unpack(reg_wdata);
      if (int'(reg_addr) == OFF_WIDTH) pend_width <= reg_wdata[NS_W-1:0];
      if (int'(reg_addr) == OFF_DELAY) pend_delay <= reg_wdata[NS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cfg   <= '0;
      act_width <= NS_W'(DEF_WIDTH);
      act_delay <= NS_W'(DEF_DELAY);
    end else if (load) begin
      act_cfg   <= pend_cfg;
      act_width <= pend_width;
      act_delay <= pend_delay;
    end
  end

  assign eff_cfg   = load ? pend_cfg   : act_cfg;
  assign eff_width = load ? pend_width : act_width;
  assign eff_delay = load ? pend_delay : act_delay;
  assign eff_pol   = eff_cfg.pol;
  assign eff_sync  = eff_cfg.sync;
  assign eff_act   = eff_cfg.act;
  assign unused_bits = ^{eff_cfg.dom, reg_wdata[31:NS_W]};

  generate
    if (SEC_W > 32) begin : g_wide_sec
      assign sec_hi = 32'(tod_sec[SEC_W-1:32]);
      assign sec_lo = tod_sec[31:0];
    end else begin : g_narrow_sec
      assign sec_hi = '0;
      assign sec_lo = 32'(tod_sec);
    end
  endgenerate

  always_comb begin
    if      (int'(reg_addr) == OFF_CFG)    reg_rdata = cfg_pack(pend_cfg);
    else if (int'(reg_addr) == OFF_SEC_HI) reg_rdata = sec_hi;
    else if (int'(reg_addr) == OFF_SEC_LO) reg_rdata = sec_lo;
    else if (int'(reg_addr) == OFF_NSEC)   reg_rdata = 32'(tod_ns);
    else if (int'(reg_addr) == OFF_WIDTH)  reg_rdata = 32'(pend_width);
    else if (int'(reg_addr) == OFF_DELAY)  reg_rdata = 32'(pend_delay);
    else                                   reg_rdata = '0;
  end

  // R8: working copy moves only at a seconds step
  p_hold_between_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_cfg) && $stable(act_width) && $stable(act_delay)));
  // R8: at a seconds step the working copy takes the pending values
  p_load_from_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (act_cfg == $past(pend_cfg) && act_width == $past(pend_width)
              && act_delay == $past(pend_delay)));
endmodule

// File: rtl/pps_wave_core.sv
module pps_wave_core
  import pps_pkg::*;
#(
  parameter int NS_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_pol,
  input  logic             cfg_sync,
  input  logic [ACT_W-1:0] cfg_act,
  input  logic [NS_W-1:0]  win_width,
  input  logic [NS_W-1:0]  win_delay,
  input  logic [NS_W-1:0]  tod_ns,
  input  logic [NS_W:0]    ns_delta,
  output logic             pulse_out
);
  localparam int SUM_W = NS_W + 1;
  localparam int ACC_W = NS_W + 2;

  logic             clk_act, sync_mode, free_mode;
  logic [SUM_W-1:0] win_end, phase_q, phase_d;
  logic [ACC_W-1:0] acc, acc_wrap;
  logic             sync_level, free_level, level;

  assign clk_act   = (cfg_act == ACT_CLOCK);
  assign sync_mode = clk_act && cfg_sync;
  assign free_mode = clk_act && !cfg_sync;

  always_comb begin
    win_end    = SUM_W'(win_delay) + SUM_W'(win_width);
    sync_level = (tod_ns >= win_delay) && (SUM_W'(tod_ns) < win_end);
    acc        = ACC_W'(phase_q) + ACC_W'(ns_delta);
    acc_wrap   = (acc >= ACC_W'(win_end)) ? acc - ACC_W'(win_end) : acc;
    free_level = (win_end != '0) && (acc_wrap >= ACC_W'(win_delay));
    phase_d    = (free_mode && win_end != '0) ? SUM_W'(acc_wrap) : '0;
    if (sync_mode)      level = sync_level;
    else if (free_mode) level = free_level;
    else                level = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= '0;
      pulse_out <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      pulse_out <= level ^ cfg_pol;
    end
  end

  // R7: idle and unknown actions hold the inactive level
  p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_act |=> (pulse_out == $past(cfg_pol)));
  // R4: no pulse before the programmed delay in aligned mode
  p_quiet_before_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && tod_ns < win_delay) |=> (pulse_out == $past(cfg_pol)));
  // R9: phase stays inside one period
  p_phase_in_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (free_mode && win_end != '0) |=> (phase_q < $past(win_end)));
endmodule

// File: rtl/pps_pulse_gen.sv
module pps_pulse_gen
  import pps_pkg::*;
#(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 30,
  parameter int ADDR_W     = 8,
  parameter int NS_PER_SEC = 1000000000,
  parameter int DEF_WIDTH  = 1000,
  parameter int DEF_DELAY  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEC_W-1:0]  tod_sec,
  input  logic [NS_W-1:0]   tod_ns,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              pulse_out
);
  logic             sec_tick;
  logic [NS_W:0]    ns_delta;
  logic             eff_pol, eff_sync;
  logic [ACT_W-1:0] eff_act;
  logic [NS_W-1:0]  eff_width, eff_delay;

  pps_tod_edge #(.SEC_W(SEC_W), .NS_W(NS_W), .NS_PER_SEC(NS_PER_SEC)) u_edge (
    .clk(clk), .rst_n(rst_n), .tod_sec(tod_sec), .tod_ns(tod_ns),
    .sec_tick(sec_tick), .ns_delta(ns_delta));

  pps_cfg_regs #(.SEC_W(SEC_W), .NS_W(NS_W), .ADDR_W(ADDR_W),
                 .DEF_WIDTH(DEF_WIDTH), .DEF_DELAY(DEF_DELAY)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tod_sec(tod_sec),
    .tod_ns(tod_ns), .load(sec_tick), .eff_pol(eff_pol), .eff_sync(eff_sync),
    .eff_act(eff_act), .eff_width(eff_width), .eff_delay(eff_delay));

  pps_wave_core #(.NS_W(NS_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cfg_pol(eff_pol), .cfg_sync(eff_sync),
    .cfg_act(eff_act), .win_width(eff_width), .win_delay(eff_delay),
    .tod_ns(tod_ns), .ns_delta(ns_delta), .pulse_out(pulse_out));
endmodule

// File: tb/pps_pulse_gen_test.sv
`timescale 1ns/1ps
module pps_pulse_gen_test;
  localparam int  SEC_W = 48, NS_W = 30, ADDR_W = 8;
  localparam longint NPS = 2000;
  localparam longint STEP = 8;
  localparam int A_CFG = 'h00, A_SHI = 'h04, A_SLO = 'h08, A_NS = 'h0C,
                 A_WID = 'h14, A_DLY = 'h18;

  logic clk = 0, rst_n = 0;
  logic [SEC_W-1:0] tod_sec;
  logic [NS_W-1:0]  tod_ns;
  logic reg_wr = 0;
  logic [ADDR_W-1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic pulse_out;

  always #4 clk = ~clk;

  pps_pulse_gen #(.SEC_W(SEC_W), .NS_W(NS_W), .ADDR_W(ADDR_W),
                  .NS_PER_SEC(int'(NPS))) uut (
    .clk(clk), .rst_n(rst_n), .tod_sec(tod_sec), .tod_ns(tod_ns),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pulse_out(pulse_out));

  int checks = 0, fails = 0;
  string tag = "R1";
  longint g_sec = 64'h1_0000_0005, g_ns = 0;
  // reference model state
  longint p_cfg = 0, p_wid = 1000, p_dly = 0;
  longint a_cfg = 0, a_wid = 1000, a_dly = 0;
  longint m_phase = 0, m_psec = 0, m_pns = 0;
  bit m_pvalid = 0;
  bit cnt_en = 0, prev_out = 0;
  int rises = 0, ticks = 0;

  task automatic chk(input bit ok, input string t, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", t, got, exp, $time);
    end
  endtask

  function automatic bit model_cycle(input bit wr, input int addr, input longint data);
    bit tick, pol, sync, lvl;
    longint act, delta, per, acc;
    tick = m_pvalid && (g_sec != m_psec);
    if (tick) begin a_cfg = p_cfg; a_wid = p_wid; a_dly = p_dly; end
    if (!m_pvalid) delta = 0;
    else if (tick) delta = g_ns + NPS - m_pns;
    else delta = g_ns - m_pns;
    pol = a_cfg[1]; sync = a_cfg[2]; act = (a_cfg >> 3) & 7;
    lvl = 0;
    if (act == 1 && sync) begin
      lvl = (g_ns >= a_dly) && (g_ns < a_dly + a_wid);
      m_phase = 0;
    end else if (act == 1) begin
      per = a_dly + a_wid;
      if (per == 0) m_phase = 0;
      else begin
        acc = m_phase + delta;
        if (acc >= per) acc -= per;
        m_phase = acc;
        lvl = (acc >= a_dly);
      end
    end else m_phase = 0;
    if (tick && cnt_en) ticks++;
    if (wr) begin
      if (addr == A_CFG) p_cfg = data & 64'h3F;
      if (addr == A_WID) p_wid = data & 64'h3FFF_FFFF;
      if (addr == A_DLY) p_dly = data & 64'h3FFF_FFFF;
    end
    m_pvalid = 1; m_psec = g_sec; m_pns = g_ns;
    return lvl ^ pol;
  endfunction

  task automatic step(input bit wr, input int addr, input longint data);
    bit exp;
    @(negedge clk);
    g_ns += STEP;
    if (g_ns >= NPS) begin g_ns -= NPS; g_sec++; end
    tod_sec = SEC_W'(g_sec); tod_ns = NS_W'(g_ns);
    reg_wr = wr; reg_addr = ADDR_W'(addr); reg_wdata = 32'(data);
    exp = model_cycle(wr, addr, data);
    @(posedge clk); #1;
    chk(pulse_out === exp, tag, longint'(pulse_out), longint'(exp));
    if (cnt_en && pulse_out && !prev_out) rises++;
    prev_out = pulse_out;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic to_tick_edge();
    while (g_ns + STEP < NPS) step(0, 0, 0);
  endtask

  task automatic rd(input int addr, input longint exp, input string t);
    reg_wr = 0; reg_addr = ADDR_W'(addr); #1;
    chk(reg_rdata === 32'(exp), t, longint'(reg_rdata), exp);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tod_sec = SEC_W'(g_sec); tod_ns = NS_W'(g_ns);
    repeat (3) @(posedge clk);
    #1;
    chk(pulse_out === 1'b0, "R1 reset out", longint'(pulse_out), 0);
    rd(A_CFG, 0, "R1 cfg"); rd(A_WID, 1000, "R1 width"); rd(A_DLY, 0, "R1 delay");
    rst_n = 1;

    tag = "R1/R7 idle after reset"; run(300);
    rd(A_SHI, g_sec >> 32, "R2 sec hi"); rd(A_SLO, g_sec & 64'hFFFF_FFFF, "R2 sec lo");
    rd(A_NS, g_ns, "R2 nsec"); rd('h10, 0, "R2 unmapped");
    tag = "R2 ro write"; step(1, A_NS, 5); rd(A_NS, g_ns, "R2 ro ignored");
    step(1, A_WID, 64'hFFFF_FFFF); rd(A_WID, 64'h3FFF_FFFF, "R2 width mask");
    step(1, A_CFG, 64'hFFFF_FFFF); rd(A_CFG, 64'h3F, "R3 cfg mask");
    step(1, A_CFG, 64'h0D); rd(A_CFG, 64'h0D, "R3 domain bit");
    step(1, A_WID, 1000);

    // aligned clock action, defaults; pending until next step
    tag = "R8 pending cfg"; step(1, A_CFG, 64'h0C);
    to_tick_edge();
    tag = "R4 aligned default"; step(0, 0, 0);
    rises = 0; ticks = 0; cnt_en = 1; prev_out = pulse_out;
    run(1000); cnt_en = 0;
    chk(rises == 4 && ticks == 4, "R4 one rise per second", rises, ticks);

    tag = "R6 polarity"; step(1, A_CFG, 64'h0E); run(500);
    tag = "R4 delay 300 width 500";
    step(1, A_CFG, 64'h0C); step(1, A_DLY, 300); step(1, A_WID, 500); run(750);

    // write mid-pulse: must not shorten running pulse
    tag = "R8 mid-pulse write";
    while (!(g_ns > 400 && g_ns < 700)) step(0, 0, 0);
    step(1, A_WID, 100); run(300);
    // write exactly on the step cycle waits for the next step
    tag = "R8 write on step"; to_tick_edge(); step(1, A_WID, 900); run(500);

    tag = "R5 truncation"; step(1, A_DLY, 1500); step(1, A_WID, 1000);
    run(300); to_tick_edge();
    chk(pulse_out === 1'b1, "R5 high before step", longint'(pulse_out), 1);
    step(0, 0, 0);
    chk(pulse_out === 1'b0, "R5 cut at step", longint'(pulse_out), 0);
    run(500);

    tag = "R7 unknown action"; step(1, A_CFG, 64'h2C); run(300);
    tag = "R7 idle inverted"; step(1, A_CFG, 64'h02); run(300);
    chk(pulse_out === 1'b1, "R7 idle pol level", longint'(pulse_out), 1);

    tag = "R9 free-running";
    step(1, A_CFG, 64'h08); step(1, A_DLY, 40); step(1, A_WID, 24); run(600);
    tag = "R9 free-running inverted"; step(1, A_CFG, 64'h0A); run(300);
    tag = "R9 zero period"; step(1, A_DLY, 0); step(1, A_WID, 0); run(300);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule